// File: doc/BRIEF.md
# NAND Host Interface Mode Switch Controller

This block lives in the command front end of a flash device. It keeps track of which host interface is active: the legacy asynchronous, strobe-timed interface or the synchronous double-data-rate interface. It sees the byte stream that the pad logic has already decoded, one byte per cycle, with one qualifier each for command, address and data. From that stream it picks out the set-feature command that addresses the interface-select feature.

When such a request is valid, the block holds the device busy for a fixed changeover interval. It commits the requested interface on the last cycle of that interval. The interval runs even when the request names the interface that is already active. A request with an unknown feature or an unusable mode value ends at once, with no busy time and no change.

Downstream data-path logic reads the mode flag. It also gets a one-cycle pulse at the moment the interface really changes, so it can switch its capture scheme.

Top module: `nandIfModeSwitch`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, modeSync is 0 (asynchronous), ready is 1, switching is 0 and modeChangePulse is 0.
- R2: Only a command byte equal to 0xEF starts a request. Any other opcode followed by the same address and data bytes leaves all outputs unchanged.
- R3: A request is the 0xEF command, then one address byte, then four data bytes. It is valid when the address byte equals FEATURE_SEL (default 0x01) and the first data byte is 0x00 (asynchronous) or 0x01 (synchronous). A command byte that arrives before the fourth data byte abandons the request, and if that byte is 0xEF it starts a new one.
- R4: A valid request drives ready low for exactly CHANGE_CYCLES cycles. The low period begins in the cycle after the fourth data byte is sampled.
- R5: modeSync keeps its old value for the whole busy interval. It takes the requested value on the same clock edge at which ready returns high.
- R6: A change is possible in both directions, asynchronous to synchronous and back, any number of times.
- R7: Command, address and data bytes that arrive while ready is low are ignored. They neither extend the interval, nor start a new one, nor change the mode.
- R8: A valid request for the interface that is already active still holds ready low for CHANGE_CYCLES cycles. It leaves modeSync unchanged, keeps switching low and produces no pulse.
- R9: A request with an address byte other than FEATURE_SEL, or with a first data byte other than 0x00 or 0x01, produces no busy cycle and no mode change.
- R10: modeChangePulse is high for exactly one cycle, in the first ready cycle after an interval, and only when modeSync changed value at that edge.
- R11: switching is high in every busy cycle of an interval whose target differs from the active interface, and low at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | busByte holds a command byte this cycle |
| addrValid | input | 1 | busByte holds an address byte this cycle |
| dataValid | input | 1 | busByte holds a data byte this cycle |
| busByte | input | 8 | Decoded byte from the host bus |
| modeSync | output | 1 | 1 = synchronous DDR interface active, 0 = asynchronous |
| ready | output | 1 | 0 while a changeover interval runs |
| switching | output | 1 | High during an interval that will change the mode |
| modeChangePulse | output | 1 | One-cycle strobe when the new mode takes effect |

## Verification
The fourth data byte is sampled at edge k. The bench then expects ready to be low from edge k onward and counts the low cycles one at a time. It expects ready high again after edge k+CHANGE_CYCLES, and modeSync and the pulse must show their new values in that same sample. The bench drives each byte half a period before the edge that samples it and reads the outputs half a period after that edge. Every comparison therefore falls in a known cycle, and the rule for ignoring bytes is checked by placing a whole competing request inside the busy window and then reading the mode after it closes.

// File: rtl/nandIfSwitchPkg.sv
package nandIfSwitchPkg;

  localparam logic [7:0] OP_SET_FEATURE  = 8'hEF;
  localparam logic [7:0] MODE_CODE_ASYNC = 8'h00;
  localparam logic [7:0] MODE_CODE_SYNC  = 8'h01;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_PARAM0,
    ST_PARAM1,
    ST_PARAM2,
    ST_PARAM3,
    ST_WAIT
  } seqState_t;

  typedef struct packed {
    logic capAddr;
    logic capParam;
    logic startWait;
    logic tick;
    logic commit;
  } ctrlStrobe_t;

endpackage

// File: rtl/ifSwitchCtrl.sv
module ifSwitchCtrl
  import nandIfSwitchPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cmdValid,
  input  logic        addrValid,
  input  logic        dataValid,
  input  logic [7:0]  busByte,
  input  logic        requestOk,
  input  logic        countDone,
  output ctrlStrobe_t strobes,
  output logic        waiting
);

  seqState_t state, stateNext;
  logic      isSetFeature;
  seqState_t abortState;

  assign isSetFeature = (busByte == OP_SET_FEATURE);
  // a command byte mid-request drops it; a fresh 0xEF restarts it
  assign abortState   = isSetFeature ? ST_ADDR : ST_IDLE;

  always_comb begin
    stateNext = state;
    strobes   = '0;
    unique case (state)
      ST_IDLE: begin
        if (cmdValid && isSetFeature) stateNext = ST_ADDR;
      end
      ST_ADDR: begin
        if (cmdValid) stateNext = abortState;
        else if (addrValid) begin
          strobes.capAddr = 1'b1;
          stateNext       = ST_PARAM0;
        end
      end
      ST_PARAM0: begin
        if (cmdValid) stateNext = abortState;
        else if (dataValid) begin
          strobes.capParam = 1'b1;
          stateNext        = ST_PARAM1;
        end
      end
      ST_PARAM1: begin
        if (cmdValid) stateNext = abortState;
        else if (dataValid) stateNext = ST_PARAM2;
      end
      ST_PARAM2: begin
        if (cmdValid) stateNext = abortState;
        else if (dataValid) stateNext = ST_PARAM3;
      end
      ST_PARAM3: begin
        if (cmdValid) stateNext = abortState;
        else if (dataValid) begin
          if (requestOk) begin
            strobes.startWait = 1'b1;
            stateNext         = ST_WAIT;
          end else begin
            stateNext = ST_IDLE;
          end
        end
      end
      ST_WAIT: begin
        strobes.tick = 1'b1;
        if (countDone) begin
          strobes.commit = 1'b1;
          stateNext      = ST_IDLE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign waiting = (state == ST_WAIT);

endmodule

// File: rtl/ifSwitchDatapath.sv
module ifSwitchDatapath
  import nandIfSwitchPkg::*;
#(
  parameter logic [7:0] FEATURE_SEL   = 8'h01,
  parameter int         CHANGE_CYCLES = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [7:0]  busByte,
  input  ctrlStrobe_t strobes,
  input  logic        waiting,
  output logic        requestOk,
  output logic        countDone,
  output logic        modeSync,
  output logic        switching,
  output logic        modePulse
);

  localparam int CNT_W = (CHANGE_CYCLES > 1) ? $clog2(CHANGE_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(CHANGE_CYCLES - 1);

  logic [7:0]       featAddr;
  logic [7:0]       paramByte;
  logic             targetSync;
  logic             modeReg;
  logic             pulseReg;
  logic [CNT_W-1:0] count;
  logic             paramValid;

  assign paramValid = (paramByte == MODE_CODE_ASYNC) || (paramByte == MODE_CODE_SYNC);
  assign requestOk  = (featAddr == FEATURE_SEL) && paramValid;
  assign countDone  = (count == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      featAddr  <= '0;
      paramByte <= '0;
    end else begin
      if (strobes.capAddr)  featAddr  <= busByte;
      if (strobes.capParam) paramByte <= busByte;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count      <= '0;
      targetSync <= 1'b0;
    end else if (strobes.startWait) begin
      count      <= CNT_LOAD;
      targetSync <= (paramByte == MODE_CODE_SYNC);
    end else if (strobes.tick && !countDone) begin
      count <= count - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeReg  <= 1'b0;
      pulseReg <= 1'b0;
    end else if (strobes.commit) begin
      modeReg  <= targetSync;
      pulseReg <= (targetSync != modeReg);
    end else begin
      pulseReg <= 1'b0;
    end
  end

  assign modeSync  = modeReg;
  assign modePulse = pulseReg;
  assign switching = waiting && (targetSync != modeReg);

endmodule

// File: rtl/nandIfModeSwitch.sv
module nandIfModeSwitch
  import nandIfSwitchPkg::*;
#(
  parameter logic [7:0] FEATURE_SEL   = 8'h01,
  parameter int         CHANGE_CYCLES = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  input  logic       addrValid,
  input  logic       dataValid,
  input  logic [7:0] busByte,
  output logic       modeSync,
  output logic       ready,
  output logic       switching,
  output logic       modeChangePulse
);

  ctrlStrobe_t strobes;
  logic        waiting;
  logic        requestOk;
  logic        countDone;

  ifSwitchCtrl i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .cmdValid  (cmdValid),
    .addrValid (addrValid),
    .dataValid (dataValid),
    .busByte   (busByte),
    .requestOk (requestOk),
    .countDone (countDone),
    .strobes   (strobes),
    .waiting   (waiting)
  );

  ifSwitchDatapath #(
    .FEATURE_SEL   (FEATURE_SEL),
    .CHANGE_CYCLES (CHANGE_CYCLES)
  ) i_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .busByte   (busByte),
    .strobes   (strobes),
    .waiting   (waiting),
    .requestOk (requestOk),
    .countDone (countDone),
    .modeSync  (modeSync),
    .switching (switching),
    .modePulse (modeChangePulse)
  );

  assign ready = !waiting;

endmodule

// File: rtl/nandIfModeSwitchChecker.sv
module nandIfModeSwitchChecker (
  input logic clk,
  input logic rstN,
  input logic modeSync,
  input logic ready,
  input logic switching,
  input logic modeChangePulse
);

  logic wasInReset;

  always_ff @(posedge clk) wasInReset <= !rstN;

  // R1: first cycle after reset shows the asynchronous mode and ready
  always_ff @(posedge clk) begin
    if (rstN && wasInReset) begin
      p_reset_state_r1: assert (!modeSync && ready && !switching && !modeChangePulse)
        else $error("reset state violated");
    end
  end

  // R5
  p_mode_moves_only_with_ready_r5: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(modeSync) |-> (ready && !$past(ready)));

  // R10
  p_pulse_single_r10: assert property (@(posedge clk) disable iff (!rstN)
    modeChangePulse |=> !modeChangePulse);

  p_pulse_after_busy_r10: assert property (@(posedge clk) disable iff (!rstN)
    modeChangePulse |-> (ready && !$past(ready) && !$stable(modeSync)));

  // R11
  p_switching_only_busy_r11: assert property (@(posedge clk) disable iff (!rstN)
    switching |-> !ready);

  // R8
  p_busy_end_without_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    (ready && !$past(ready) && $stable(modeSync)) |-> !modeChangePulse);

endmodule

bind nandIfModeSwitch nandIfModeSwitchChecker i_checker (
  .clk             (clk),
  .rstN            (rstN),
  .modeSync        (modeSync),
  .ready           (ready),
  .switching       (switching),
  .modeChangePulse (modeChangePulse)
);

// File: tb/test_nandIfModeSwitch.sv
module test_nandIfModeSwitch;

  localparam int         TITC = 6;
  localparam logic [7:0] FSEL = 8'h01;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cmdValid = 1'b0;
  logic       addrValid = 1'b0;
  logic       dataValid = 1'b0;
  logic [7:0] busByte = 8'h00;
  logic       modeSync, ready, switching, modeChangePulse;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  nandIfModeSwitch #(.FEATURE_SEL(FSEL), .CHANGE_CYCLES(TITC)) i_nandIfModeSwitch (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .addrValid(addrValid),
    .dataValid(dataValid), .busByte(busByte), .modeSync(modeSync),
    .ready(ready), .switching(switching), .modeChangePulse(modeChangePulse)
  );

  typedef struct packed {
    logic [7:0] addr;
    logic [7:0] p0;
    logic [7:0] busy;
    logic       mode;
    logic       pulse;
  } vec_t;

  // addr, first data byte, expected busy cycles, mode after, pulse expected
  localparam vec_t VECS [8] = '{
    '{8'h01, 8'h01, 8'(TITC), 1'b1, 1'b1},
    '{8'h01, 8'h01, 8'(TITC), 1'b1, 1'b0},
    '{8'h01, 8'h00, 8'(TITC), 1'b0, 1'b1},
    '{8'h02, 8'h01, 8'd0,     1'b0, 1'b0},
    '{8'h01, 8'h07, 8'd0,     1'b0, 1'b0},
    '{8'h01, 8'h00, 8'(TITC), 1'b0, 1'b0},
    '{8'h01, 8'h01, 8'(TITC), 1'b1, 1'b1},
    '{8'h01, 8'h00, 8'(TITC), 1'b0, 1'b1}
  };

  task automatic checkVal(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // byte is set up here and sampled at the next rising edge; returns at the following falling edge
  task automatic sendByte(input int kind, input logic [7:0] val);
    cmdValid  = (kind == 0);
    addrValid = (kind == 1);
    dataValid = (kind == 2);
    busByte   = val;
    @(negedge clk);
    cmdValid  = 1'b0;
    addrValid = 1'b0;
    dataValid = 1'b0;
  endtask

  task automatic sendRequest(input logic [7:0] op, input logic [7:0] addr, input logic [7:0] p0);
    sendByte(0, op);
    sendByte(1, addr);
    sendByte(2, p0);
    sendByte(2, 8'h00);
    sendByte(2, 8'h00);
    sendByte(2, 8'h00);
  endtask

  // count busy cycles, checking the mode is held and switching is correct in each one
  task automatic measureBusy(input logic oldMode, input logic expSwitch, output int busyCnt);
    busyCnt = 0;
    while (!ready && busyCnt < 40) begin
      checkVal("R5 mode held during interval", modeSync, oldMode);
      checkVal("R11/R8 switching during interval", switching, expSwitch);
      busyCnt++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int busyCnt;
    logic oldMode;
    repeat (3) @(negedge clk);
    checkVal("R1 reset modeSync", modeSync, 0);
    checkVal("R1 reset ready", ready, 1);
    rstN = 1'b1;
    @(negedge clk);
    checkVal("R1 post-reset modeSync", modeSync, 0);
    checkVal("R1 post-reset ready", ready, 1);
    checkVal("R1 post-reset switching", switching, 0);
    checkVal("R1 post-reset pulse", modeChangePulse, 0);

    // table walk: R3 R4 R6 R8 R9 R10
    for (int i = 0; i < 8; i++) begin
      oldMode = modeSync;
      sendRequest(8'hEF, VECS[i].addr, VECS[i].p0);
      measureBusy(oldMode, VECS[i].pulse, busyCnt);
      checkVal("R4/R9 busy length", busyCnt, int'(VECS[i].busy));
      checkVal("R6/R8 mode after", modeSync, VECS[i].mode);
      checkVal("R10 pulse at first ready", modeChangePulse, VECS[i].pulse);
      @(negedge clk);
      checkVal("R10 pulse one cycle", modeChangePulse, 0);
      checkVal("R11 switching idle", switching, 0);
    end

    // R2: another opcode does nothing
    sendRequest(8'hEE, FSEL, 8'h01);
    checkVal("R2 non-EF ready", ready, 1);
    repeat (2) @(negedge clk);
    checkVal("R2 non-EF mode", modeSync, 0);

    // R3: command byte mid-request abandons it
    sendByte(0, 8'hEF);
    sendByte(1, FSEL);
    sendByte(2, 8'h01);
    sendByte(0, 8'h70);
    sendByte(2, 8'h00);
    sendByte(2, 8'h00);
    sendByte(2, 8'h00);
    checkVal("R3 abort ready", ready, 1);
    checkVal("R3 abort mode", modeSync, 0);

    // R3: a second 0xEF restarts the request
    sendByte(0, 8'hEF);
    sendByte(1, FSEL);
    sendRequest(8'hEF, FSEL, 8'h01);
    measureBusy(1'b0, 1'b1, busyCnt);
    checkVal("R3 restart busy", busyCnt, TITC);
    checkVal("R3 restart mode", modeSync, 1);
    @(negedge clk);

    // R7: full request inside the busy window is ignored
    sendRequest(8'hEF, FSEL, 8'h00);
    checkVal("R7 first interval ready", ready, 0);
    sendRequest(8'hEF, FSEL, 8'h01);
    checkVal("R7 ready after single interval", ready, 1);
    checkVal("R7 mode from first request", modeSync, 0);
    repeat (3) @(negedge clk);
    checkVal("R7 no second interval", ready, 1);
    checkVal("R7 mode unchanged", modeSync, 0);

    // R1: reset in the middle of an interval
    sendRequest(8'hEF, FSEL, 8'h01);
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checkVal("R1 reset mid-interval mode", modeSync, 0);
    checkVal("R1 reset mid-interval ready", ready, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule